// File: doc/BRIEF.md
# Boosted-Exception Recovery Fetch Controller

This controller sits on the instruction fetch path of a statically scheduled core. The compiler may hoist instructions above one conditional branch and mark them as boosted. The controller records the address of the first boosted instruction that follows a branch. It then takes the next branch fetched after that point as the guarding branch and records its address as well.

When the guarding branch resolves not taken while a deferred exception from a boosted instruction is outstanding, the controller asserts a one-cycle fetch redirect back to the saved address. In that cycle it squashes whatever fetch arrives, which is the delay-slot work. It then enters a replay phase. In replay, boosted instructions flow through one at a time in program order, so the faulting one can trap precisely, and every unmarked instruction is squashed at fetch. When fetch reaches the guarding branch again, the controller pulses an exception-clear strobe and returns to normal operation. A taken resolution, or a not-taken resolution with no exception, discards the saved addresses without redirecting.

Top module: `brx_fetch_ctl`

## Requirements
- R1: After a synchronous reset, `mode` is 0 (normal), and `redirect_valid`, `redirect_pc`, `squash` and `exc_clear` are all 0.
- R2: In normal mode, the PC of the first boosted fetch seen while no address is saved is stored. Later boosted fetches do not replace it, and the stored value is what appears on `redirect_pc` during a redirect.
- R3: The first branch fetched after a boosted address has been stored becomes the guarding branch. A branch fetched while no boosted address is stored is not a guard.
- R4: A not-taken commit with `exc_pending` high, in normal mode with both addresses stored, makes `mode`=1 (redirect) and `redirect_valid`=1 in the next cycle. This lasts exactly one cycle and is followed by `mode`=2 (replay).
- R5: While `mode`=1, every valid fetch is squashed (delay-slot work, boosted or not).
- R6: A taken commit produces no redirect, even with `exc_pending` high, and discards the stored addresses so that the next boosted fetch is captured afresh.
- R7: A not-taken commit with `exc_pending` low produces no redirect and discards the stored addresses.
- R8: While `mode`=2, a valid fetch with the boosted mark is not squashed. A valid unmarked fetch whose PC differs from the guard is squashed.
- R9: In replay, a valid fetch at the guard PC is not squashed and raises `exc_clear` in that cycle. `mode` is 0 in the next cycle, and the stored addresses are discarded.
- R10: A not-taken commit with `exc_pending` high but no stored boosted address produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetched instruction is present |
| fetch_pc | input | PC_W | Address of the fetched instruction |
| fetch_boosted | input | 1 | Fetched instruction carries the boosted mark |
| fetch_branch | input | 1 | Fetched instruction is a conditional branch |
| commit_valid | input | 1 | A branch resolves this cycle |
| commit_taken | input | 1 | Direction of the resolving branch |
| exc_pending | input | 1 | A deferred boosted exception is recorded |
| redirect_valid | output | 1 | Redirect fetch to `redirect_pc` |
| redirect_pc | output | PC_W | Saved first-boosted address (0 when not redirecting) |
| squash | output | 1 | Kill the current fetch |
| mode | output | 2 | 0 normal, 1 redirect, 2 replay |
| exc_clear | output | 1 | Guard reached in replay; clear the exception record |

## Verification
The embedded properties cover behaviours that hold on every cycle. A redirect always lasts exactly one cycle before replay. Every fetch is squashed in redirect mode and none is squashed in normal mode. Boosted fetches always pass in replay. A clear strobe always returns the controller to normal. A saved address never changes while it is held. Other properties depend on a particular history and can only be shown by the bench's scenarios: that the first boosted address wins over later ones, that the right branch becomes the guard, that taken or exception-free commits leave nothing behind for a later window, and that a commit with no saved address is ignored.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_REDIRECT = 2'd1,
        MODE_REPLAY   = 2'd2
    } brx_mode_e;

    typedef struct packed {
        logic valid;
        logic boosted;
        logic is_branch;
    } fetch_tag_t;

    typedef struct packed {
        logic valid;
        logic taken;
    } commit_t;

    // Recovery starts only on a not-taken resolution with an exception outstanding
    // and a complete boosted window (start address and guard both recorded).
    function automatic logic recovery_trigger(commit_t c, logic exc, logic window_ok);
        return c.valid && !c.taken && exc && window_ok;
    endfunction

endpackage

// File: rtl/brx_pc_tracker.sv
module brx_pc_tracker
    import brx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  fetch_tag_t       ftag,
    input  logic [PC_W-1:0]  fpc,
    input  brx_mode_e        mode,
    input  commit_t          cmt,
    input  logic             exc_pending,
    input  logic             replay_done,
    output logic [PC_W-1:0]  bpc,
    output logic             bpc_vld,
    output logic [PC_W-1:0]  gpc,
    output logic             gpc_vld
);

    logic in_normal;
    logic trig;
    logic discard;

    assign in_normal = (mode == MODE_NORMAL);
    assign trig      = recovery_trigger(cmt, exc_pending, bpc_vld && gpc_vld);
    assign discard   = replay_done || (in_normal && cmt.valid && !trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            bpc     <= '0;
            bpc_vld <= 1'b0;
            gpc     <= '0;
            gpc_vld <= 1'b0;
        end else if (discard) begin
            bpc_vld <= 1'b0;
            gpc_vld <= 1'b0;
        end else if (in_normal && ftag.valid) begin
            if (ftag.boosted && !bpc_vld) begin
                bpc     <= fpc;
                bpc_vld <= 1'b1;
            end
            if (ftag.is_branch && bpc_vld && !gpc_vld) begin
                gpc     <= fpc;
                gpc_vld <= 1'b1;
            end
        end
    end

    // R2: a held start address is never overwritten
    a_r2_start_pc_held: assert property (@(posedge clk) disable iff (rst)
        bpc_vld |=> $stable(bpc));

    // R3: a guard exists only once a boosted start address is held
    a_r3_guard_needs_start: assert property (@(posedge clk) disable iff (rst)
        gpc_vld |-> bpc_vld);

endmodule

// File: rtl/brx_fetch_filter.sv
module brx_fetch_filter
    import brx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  brx_mode_e        mode,
    input  fetch_tag_t       ftag,
    input  logic [PC_W-1:0]  fpc,
    input  logic [PC_W-1:0]  gpc,
    input  logic             gpc_vld,
    output logic             squash,
    output logic             guard_hit
);

    always_comb begin
        guard_hit = (mode == MODE_REPLAY) && ftag.valid && gpc_vld && (fpc == gpc);
        unique case (mode)
            MODE_REDIRECT: squash = ftag.valid;
            MODE_REPLAY:   squash = ftag.valid && !ftag.boosted && !guard_hit;
            default:       squash = 1'b0;
        endcase
    end

endmodule

// File: rtl/brx_fsm.sv
module brx_fsm
    import brx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  commit_t    cmt,
    input  logic       exc_pending,
    input  logic       window_ok,
    input  logic       guard_hit,
    output brx_mode_e  mode,
    output logic       redirect_valid,
    output logic       exc_clear
);

    brx_mode_e nxt;

    always_comb begin
        nxt = mode;
        unique case (mode)
            MODE_NORMAL:   if (recovery_trigger(cmt, exc_pending, window_ok)) nxt = MODE_REDIRECT;
            MODE_REDIRECT: nxt = MODE_REPLAY;
            MODE_REPLAY:   if (guard_hit) nxt = MODE_NORMAL;
            default:       nxt = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_NORMAL;
        else     mode <= nxt;
    end

    assign redirect_valid = (mode == MODE_REDIRECT);
    assign exc_clear      = (mode == MODE_REPLAY) && guard_hit;

    // R4: redirect is a single cycle, always followed by replay
    a_r4_redirect_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REDIRECT) |=> (mode == MODE_REPLAY));

    // R6: a taken resolution in normal mode never redirects
    a_r6_taken_no_redirect: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && cmt.valid && cmt.taken) |=> !redirect_valid);

    // R9: the clear strobe hands control back to normal fetch
    a_r9_clear_to_normal: assert property (@(posedge clk) disable iff (rst)
        exc_clear |=> (mode == MODE_NORMAL));

endmodule

// File: rtl/brx_fetch_ctl.sv
module brx_fetch_ctl
    import brx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             fetch_boosted,
    input  logic             fetch_branch,
    input  logic             commit_valid,
    input  logic             commit_taken,
    input  logic             exc_pending,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             squash,
    output logic [1:0]       mode,
    output logic             exc_clear
);

    fetch_tag_t      ftag;
    commit_t         cmt;
    brx_mode_e       st;
    logic [PC_W-1:0] bpc;
    logic [PC_W-1:0] gpc;
    logic            bpc_vld;
    logic            gpc_vld;
    logic            guard_hit;

    assign ftag = '{valid: fetch_valid, boosted: fetch_boosted, is_branch: fetch_branch};
    assign cmt  = '{valid: commit_valid, taken: commit_taken};

    brx_pc_tracker #(.PC_W(PC_W)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .ftag        (ftag),
        .fpc         (fetch_pc),
        .mode        (st),
        .cmt         (cmt),
        .exc_pending (exc_pending),
        .replay_done (exc_clear),
        .bpc         (bpc),
        .bpc_vld     (bpc_vld),
        .gpc         (gpc),
        .gpc_vld     (gpc_vld)
    );

    brx_fetch_filter #(.PC_W(PC_W)) u_flt (
        .mode      (st),
        .ftag      (ftag),
        .fpc       (fetch_pc),
        .gpc       (gpc),
        .gpc_vld   (gpc_vld),
        .squash    (squash),
        .guard_hit (guard_hit)
    );

    brx_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cmt            (cmt),
        .exc_pending    (exc_pending),
        .window_ok      (bpc_vld && gpc_vld),
        .guard_hit      (guard_hit),
        .mode           (st),
        .redirect_valid (redirect_valid),
        .exc_clear      (exc_clear)
    );

    assign mode        = st;
    assign redirect_pc = redirect_valid ? bpc : '0;

    // R5: the delay-slot fetch during redirect is always killed
    a_r5_redirect_squash: assert property (@(posedge clk) disable iff (rst)
        (st == MODE_REDIRECT && fetch_valid) |-> squash);

    // R8: marked instructions always proceed during replay
    a_r8_boosted_pass: assert property (@(posedge clk) disable iff (rst)
        (st == MODE_REPLAY && fetch_valid && fetch_boosted) |-> !squash);

    // R1: normal fetch is never squashed
    a_r1_normal_no_squash: assert property (@(posedge clk) disable iff (rst)
        (st == MODE_NORMAL) |-> !squash);

endmodule

// File: tb/sim_brx_fetch_ctl.sv
module sim_brx_fetch_ctl;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fetch_valid = 0, fetch_boosted = 0, fetch_branch = 0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            commit_valid = 0, commit_taken = 0, exc_pending = 0;
    logic            redirect_valid, squash, exc_clear;
    logic [PC_W-1:0] redirect_pc;
    logic [1:0]      mode;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int              m_st = 0;
    bit              m_bv = 0, m_gv = 0;
    logic [PC_W-1:0] m_bpc = '0, m_gpc = '0;

    // last sampled outputs
    logic s_rv, s_sq, s_clr;
    logic [PC_W-1:0] s_rpc;
    logic [1:0] s_mode;

    brx_fetch_ctl #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_boosted(fetch_boosted), .fetch_branch(fetch_branch),
        .commit_valid(commit_valid), .commit_taken(commit_taken),
        .exc_pending(exc_pending),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .squash(squash), .mode(mode), .exc_clear(exc_clear)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<5000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string tag, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // one cycle: drive, compare against model, advance model
    task automatic step(bit fv, logic [PC_W-1:0] pc, bit fb, bit fbr,
                        bit cv, bit ct, bit ex);
        bit hit, trig, clr, ob;
        bit e_sq;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_boosted = fb; fetch_branch = fbr;
        commit_valid = cv; commit_taken = ct; exc_pending = ex;
        #1;
        hit  = (m_st == 2) && fv && m_gv && (pc == m_gpc);
        e_sq = (m_st == 1) ? fv : (m_st == 2) ? (fv && !fb && !hit) : 1'b0;
        s_rv = redirect_valid; s_rpc = redirect_pc; s_sq = squash;
        s_mode = mode; s_clr = exc_clear;
        chk("R9 mode", {30'd0, s_mode}, m_st);
        chk("R4 redirect_valid", {31'd0, s_rv}, {31'd0, m_st == 1});
        chk("R2 redirect_pc", s_rpc, (m_st == 1) ? m_bpc : '0);
        chk("R8 squash", {31'd0, s_sq}, {31'd0, e_sq});
        chk("R9 exc_clear", {31'd0, s_clr}, {31'd0, hit});
        @(posedge clk);
        #1;
        trig = (m_st == 0) && cv && !ct && ex && m_bv && m_gv;
        clr  = hit || ((m_st == 0) && cv && !trig);
        ob   = m_bv;
        if (clr) begin
            m_bv = 0; m_gv = 0;
        end else if (m_st == 0 && fv) begin
            if (fb && !ob) begin m_bpc = pc; m_bv = 1; end
            if (fbr && ob && !m_gv) begin m_gpc = pc; m_gv = 1; end
        end
        case (m_st)
            0: m_st = trig ? 1 : 0;
            1: m_st = 2;
            default: m_st = hit ? 0 : 2;
        endcase
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R1 mode", {30'd0, mode}, 0);
        chk("R1 redirect_valid", {31'd0, redirect_valid}, 0);
        chk("R1 redirect_pc", redirect_pc, 0);
        chk("R1 squash", {31'd0, squash}, 0);
        chk("R1 exc_clear", {31'd0, exc_clear}, 0);
        @(negedge clk);
        rst = 0;

        // Scenario A: full recovery
        step(1, 32'h100, 0, 1, 0, 0, 0); // branch, no window: not a guard (R3)
        step(1, 32'h104, 1, 0, 0, 0, 0); // first boosted -> captured
        step(1, 32'h108, 1, 0, 0, 0, 0); // later boosted, must not overwrite
        step(1, 32'h10c, 0, 0, 0, 0, 0);
        step(1, 32'h110, 0, 1, 0, 0, 0); // guard branch
        step(1, 32'h114, 0, 0, 1, 0, 1); // commit not taken, exception
        step(1, 32'h118, 0, 0, 0, 0, 1); // delay-slot fetch during redirect
        chk("R4 redirect asserted", {31'd0, s_rv}, 1);
        chk("R2 first boosted pc", s_rpc, 32'h104);
        chk("R5 delay slot squashed", {31'd0, s_sq}, 1);
        step(1, 32'h104, 1, 0, 0, 0, 1);
        chk("R4 replay after redirect", {30'd0, s_mode}, 2);
        chk("R8 boosted passes", {31'd0, s_sq}, 0);
        step(1, 32'h108, 1, 0, 0, 0, 1);
        step(1, 32'h10c, 0, 0, 0, 0, 1);
        chk("R8 unmarked squashed", {31'd0, s_sq}, 1);
        step(1, 32'h110, 0, 1, 0, 0, 1); // guard reached
        chk("R3 guard not squashed", {31'd0, s_sq}, 0);
        chk("R9 clear pulse", {31'd0, s_clr}, 1);
        idle();
        chk("R9 back to normal", {30'd0, s_mode}, 0);

        // Scenario B: taken with exception -> nothing, then fresh capture
        step(1, 32'h200, 1, 0, 0, 0, 0);
        step(1, 32'h204, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 1, 1, 1);
        idle();
        chk("R6 no redirect on taken", {31'd0, s_rv}, 0);
        step(1, 32'h240, 1, 0, 0, 0, 0);
        step(1, 32'h244, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 1);
        step(1, 32'h248, 1, 0, 0, 0, 1);
        chk("R6 fresh capture after taken", s_rpc, 32'h240);
        chk("R5 boosted delay slot squashed", {31'd0, s_sq}, 1);
        step(1, 32'h240, 1, 0, 0, 0, 1);
        step(1, 32'h244, 0, 1, 0, 0, 1);
        idle();

        // Scenario C: not taken, no exception -> discard
        step(1, 32'h300, 1, 0, 0, 0, 0);
        step(1, 32'h304, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 0);
        idle();
        chk("R7 no redirect without exc", {31'd0, s_rv}, 0);
        step(1, 32'h320, 1, 0, 0, 0, 0);
        step(1, 32'h324, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 1);
        idle();
        chk("R7 window discarded earlier", s_rpc, 32'h320);
        step(1, 32'h320, 1, 0, 0, 0, 1);
        step(1, 32'h328, 0, 0, 0, 0, 1);
        step(1, 32'h324, 0, 1, 0, 0, 1);
        idle();

        // Scenario D: exception but no boosted window
        step(1, 32'h400, 0, 1, 0, 0, 0);
        step(1, 32'h404, 0, 0, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 1);
        idle();
        chk("R10 no redirect without window", {31'd0, s_rv}, 0);
        chk("R10 still normal", {30'd0, s_mode}, 0);
        idle();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule